// File: doc/BRIEF.md
# Multi-Mode Capture Timer/Counter

This block is a 16-bit counting engine built from two 8-bit halves. A two-bit mode register sets how the halves work. They can run as two separate prescaled timers. The low half can run as a prescaled timer while the high half counts external events. The halves can also be chained into one 16-bit prescaled timer or one 16-bit event counter. Each half compares its count against a match register. On a match it returns to zero and raises a sticky interrupt flag. Four capture strobes copy the live count into capture registers: a primary and a secondary strobe for each half.

All external event and capture lines are asynchronous. Each one passes through a two-flop synchronizer and a rising-edge detector before it can act. Software uses a simple register port for configuration and readback. A write is accepted on any cycle in which `wr_en` is high; the port has no back-pressure and never stalls. Read data is combinational from `addr`.

The register map is as follows. Addresses 0 to 4 are read/write: mode, low prescale, high prescale, low match and high match. Address 5 holds the flags and is write-1-to-clear. Addresses 6 and 7 hold the low and high counts and are read-only. Addresses 8 to 11 hold the capture registers and are read-only, in the order low primary, high primary, low secondary, high secondary.

Top module: `cap_timer`

## Requirements
- R1: After reset the mode reads 0, both prescale values read 0, both match values read 0xFF, and the counts, capture registers, flags and both irq outputs are 0.
- R2: A rising edge on `evt_in` or any `cap_in` bit that is first sampled high at clock edge k takes effect at clock edge k+2. Each line must stay high, and then low, for at least one cycle.
- R3: A prescaled half with prescale value P increments once every P+1 cycles. Its prescaler restarts from zero on a mode write.
- R4: When a count equal to its match value is about to increment, it becomes 0 instead and sets its match flag. Flag bit 0 (low or 16-bit) drives `irq_lo` and flag bit 1 (high) drives `irq_hi`.
- R5: Flags stay set until software writes a 1 to that bit at address 5. A new set event in the same cycle as a clear wins over the clear.
- R6: In mode 0 the two halves count independently, the low half with the low prescale value and the high half with the high prescale value.
- R7: In mode 1 the low half is a prescaled timer and the high half counts rising edges of `evt_in`.
- R8: In mode 2 the halves form one 16-bit timer. It uses the low prescale value and the 16-bit match value {high match, low match}, and it sets only flag bit 0.
- R9: In mode 3 the halves form one 16-bit counter of `evt_in` edges, with no prescaler.
- R10: In modes 0 and 1, strobe `cap_in[0]`/`cap_in[1]` copies the low count into the low primary/secondary capture register. Strobe `cap_in[2]`/`cap_in[3]` copies the high count into the high primary/secondary capture register. Strobe n sets flag bit 2+n.
- R11: In modes 2 and 3, `cap_in[0]`/`cap_in[1]` copy the full 16-bit count into the primary/secondary capture pair and set flag bit 2/3. `cap_in[2]` and `cap_in[3]` are ignored.
- R12: Any write to address 0, even of the current mode, clears both counts at that edge.
- R13: Configuration registers read back what was written. Writes to addresses 6 to 11 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for both reads and writes |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data for `addr` |
| evt_in | input | 1 | Asynchronous external event line |
| cap_in | input | 4 | Asynchronous capture strobes: low primary, low secondary, high primary, high secondary |
| irq_lo | output | 1 | Low-half or 16-bit match flag |
| irq_hi | output | 1 | High-half match flag |

## Verification
Some properties are checked on every cycle. A mode write clears both counts. The low count only holds, steps by one or returns to zero. A set match flag stays set until a clear write. In the 16-bit modes the count wraps on a match, the high match flag stays quiet, and the capture registers do not move without a low-half strobe. Other behaviour can only be shown by the bench's scenarios, which are compared against a behavioural model: the two-cycle synchronizer latency, the exact prescale periods, the event counts, the captured values, and the priority of set over clear.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [1:0] {
    MODE_DUAL     = 2'd0,
    MODE_TMR_EVT  = 2'd1,
    MODE_WIDE_TMR = 2'd2,
    MODE_WIDE_EVT = 2'd3
  } tc_mode_e;

  localparam int unsigned ADDR_W = 4;
  localparam int unsigned FLAG_W = 6;
  localparam int unsigned NCAP   = 4;

  localparam logic [ADDR_W-1:0] A_MODE    = 4'd0;
  localparam logic [ADDR_W-1:0] A_PRE_LO  = 4'd1;
  localparam logic [ADDR_W-1:0] A_PRE_HI  = 4'd2;
  localparam logic [ADDR_W-1:0] A_MAT_LO  = 4'd3;
  localparam logic [ADDR_W-1:0] A_MAT_HI  = 4'd4;
  localparam logic [ADDR_W-1:0] A_FLAGS   = 4'd5;
  localparam logic [ADDR_W-1:0] A_CNT_LO  = 4'd6;
  localparam logic [ADDR_W-1:0] A_CNT_HI  = 4'd7;
  localparam logic [ADDR_W-1:0] A_CAP_LO0 = 4'd8;
  localparam logic [ADDR_W-1:0] A_CAP_HI0 = 4'd9;
  localparam logic [ADDR_W-1:0] A_CAP_LO1 = 4'd10;
  localparam logic [ADDR_W-1:0] A_CAP_HI1 = 4'd11;
endpackage

// File: rtl/tc_sync_edge.sv
module tc_sync_edge #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] rise
);
  logic [N-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/tc_prescaler.sv
module tc_prescaler #(
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [PW-1:0] period,
  output logic          tick
);
  logic [PW-1:0] div_q;

  assign tick = (div_q >= period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_q <= '0;
    else if (restart) div_q <= '0;
    else if (tick)    div_q <= '0;
    else              div_q <= div_q + PW'(1);
  end
endmodule

// File: rtl/tc_capture_bank.sv
module tc_capture_bank
  import tc_pkg::*;
#(
  parameter int unsigned HW = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wide,
  input  logic [NCAP-1:0]          strobe,
  input  logic [HW-1:0]            cnt_lo,
  input  logic [HW-1:0]            cnt_hi,
  output logic [NCAP-1:0][HW-1:0]  cap_q,
  output logic [NCAP-1:0]          hit
);
  for (genvar j = 0; j < 2; j++) begin : g_slot
    logic [HW-1:0] lo_r, hi_r;
    logic          take_hi;

    assign take_hi = wide ? strobe[j] : strobe[2+j];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_r <= '0;
        hi_r <= '0;
      end else begin
        if (strobe[j]) lo_r <= cnt_lo;
        if (take_hi)   hi_r <= cnt_hi;
      end
    end

    assign cap_q[2*j]   = lo_r;
    assign cap_q[2*j+1] = hi_r;
  end

  assign hit = wide ? {2'b00, strobe[1:0]} : strobe;
endmodule

// File: rtl/cap_timer.sv
module cap_timer
  import tc_pkg::*;
#(
  parameter int unsigned HW = 8,
  parameter int unsigned PW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [HW-1:0]     wr_data,
  output logic [HW-1:0]     rd_data,
  input  logic              evt_in,
  input  logic [NCAP-1:0]   cap_in,
  output logic              irq_lo,
  output logic              irq_hi
);
  localparam int unsigned W2 = 2 * HW;

  tc_mode_e            mode_q;
  logic [1:0][PW-1:0]  pre_q;
  logic [HW-1:0]       match_lo_q, match_hi_q;
  logic [HW-1:0]       cnt_lo_q, cnt_hi_q;
  logic [FLAG_W-1:0]   flags_q;

  logic                mode_wr;
  logic [1:0]          pre_tick;
  logic [NCAP:0]       pls;
  logic                evt_pls;
  logic [NCAP-1:0]     cap_pls;
  logic [NCAP-1:0][HW-1:0] cap_q;
  logic [NCAP-1:0]     cap_hit;

  assign mode_wr = wr_en && (addr == A_MODE);

  tc_sync_edge #(.N(NCAP+1)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({cap_in, evt_in}),
    .rise     (pls)
  );
  assign evt_pls = pls[0];
  assign cap_pls = pls[NCAP:1];

  for (genvar h = 0; h < 2; h++) begin : g_pre
    tc_prescaler #(.PW(PW)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (mode_wr),
      .period  (pre_q[h]),
      .tick    (pre_tick[h])
    );
  end

  // Count sources per mode
  logic          wide;
  logic          lo_inc, hi_inc, w_inc;
  logic [W2-1:0] cnt16, match16;
  logic          lo_at, hi_at, w_at;
  logic          set_lo, set_hi;

  assign wide    = mode_q[1];
  assign lo_inc  = !wide && pre_tick[0];
  assign hi_inc  = !wide && ((mode_q == MODE_DUAL) ? pre_tick[1] : evt_pls);
  assign w_inc   = wide && ((mode_q == MODE_WIDE_TMR) ? pre_tick[0] : evt_pls);
  assign cnt16   = {cnt_hi_q, cnt_lo_q};
  assign match16 = {match_hi_q, match_lo_q};
  assign lo_at   = (cnt_lo_q == match_lo_q);
  assign hi_at   = (cnt_hi_q == match_hi_q);
  assign w_at    = (cnt16 == match16);
  assign set_lo  = !mode_wr && ((lo_inc && lo_at) || (w_inc && w_at));
  assign set_hi  = !mode_wr && hi_inc && hi_at;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo_q <= '0;
      cnt_hi_q <= '0;
    end else if (mode_wr) begin
      cnt_lo_q <= '0;
      cnt_hi_q <= '0;
    end else if (wide) begin
      if (w_inc) {cnt_hi_q, cnt_lo_q} <= w_at ? '0 : cnt16 + W2'(1);
    end else begin
      if (lo_inc) cnt_lo_q <= lo_at ? '0 : cnt_lo_q + HW'(1);
      if (hi_inc) cnt_hi_q <= hi_at ? '0 : cnt_hi_q + HW'(1);
    end
  end

  tc_capture_bank #(.HW(HW)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .wide   (wide),
    .strobe (cap_pls),
    .cnt_lo (cnt_lo_q),
    .cnt_hi (cnt_hi_q),
    .cap_q  (cap_q),
    .hit    (cap_hit)
  );

  // Sticky flags, set wins over clear
  logic [FLAG_W-1:0] flag_set, flag_clr;
  assign flag_set = {cap_hit, set_hi, set_lo};
  assign flag_clr = (wr_en && addr == A_FLAGS) ? wr_data[FLAG_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~flag_clr) | flag_set;
  end

  // Configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MODE_DUAL;
      pre_q      <= '0;
      match_lo_q <= '1;
      match_hi_q <= '1;
    end else if (wr_en) begin
      unique case (addr)
        A_MODE:   mode_q     <= tc_mode_e'(wr_data[1:0]);
        A_PRE_LO: pre_q[0]   <= wr_data[PW-1:0];
        A_PRE_HI: pre_q[1]   <= wr_data[PW-1:0];
        A_MAT_LO: match_lo_q <= wr_data;
        A_MAT_HI: match_hi_q <= wr_data;
        default:  ;
      endcase
    end
  end

  always_comb begin
    unique case (addr)
      A_MODE:    rd_data = HW'(mode_q);
      A_PRE_LO:  rd_data = HW'(pre_q[0]);
      A_PRE_HI:  rd_data = HW'(pre_q[1]);
      A_MAT_LO:  rd_data = match_lo_q;
      A_MAT_HI:  rd_data = match_hi_q;
      A_FLAGS:   rd_data = HW'(flags_q);
      A_CNT_LO:  rd_data = cnt_lo_q;
      A_CNT_HI:  rd_data = cnt_hi_q;
      A_CAP_LO0: rd_data = cap_q[0];
      A_CAP_HI0: rd_data = cap_q[1];
      A_CAP_LO1: rd_data = cap_q[2];
      A_CAP_HI1: rd_data = cap_q[3];
      default:   rd_data = '0;
    endcase
  end

  assign irq_lo = flags_q[0];
  assign irq_hi = flags_q[1];
endmodule

// File: rtl/cap_timer_chk.sv
module cap_timer_chk
  import tc_pkg::*;
#(
  parameter int unsigned HW = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     mode_wr,
  input logic                     wide,
  input logic                     w_inc,
  input logic [HW-1:0]            cnt_lo,
  input logic [HW-1:0]            cnt_hi,
  input logic [HW-1:0]            match_lo,
  input logic [HW-1:0]            match_hi,
  input logic [FLAG_W-1:0]        flags,
  input logic [FLAG_W-1:0]        flag_clr,
  input logic [NCAP-1:0]          cap_pls,
  input logic [NCAP-1:0][HW-1:0]  cap_q
);
  AST_MODE_WR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (cnt_lo == '0 && cnt_hi == '0)); // R12

  AST_LO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr |=> (cnt_lo == $past(cnt_lo) || cnt_lo == $past(cnt_lo) + HW'(1) || cnt_lo == '0)); // R3

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !flag_clr[0]) |=> flags[0]); // R5

  AST_WIDE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wide && w_inc && !mode_wr && {cnt_hi, cnt_lo} == {match_hi, match_lo})
      |=> ({cnt_hi, cnt_lo} == '0 && flags[0])); // R8

  AST_WIDE_HI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wide && !flags[1]) |=> !flags[1]); // R8

  AST_WIDE_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wide && !cap_pls[0] && !cap_pls[1]) |=> $stable(cap_q)); // R11
endmodule

bind cap_timer cap_timer_chk #(.HW(HW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_wr  (mode_wr),
  .wide     (wide),
  .w_inc    (w_inc),
  .cnt_lo   (cnt_lo_q),
  .cnt_hi   (cnt_hi_q),
  .match_lo (match_lo_q),
  .match_hi (match_hi_q),
  .flags    (flags_q),
  .flag_clr (flag_clr),
  .cap_pls  (cap_pls),
  .cap_q    (cap_q)
);

// File: tb/cap_timer_test.sv
`timescale 1ns/100ps
module cap_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       evt_in = 1'b0;
  logic [3:0] cap_in = '0;
  logic       irq_lo, irq_hi;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cap_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .evt_in(evt_in), .cap_in(cap_in),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  // Behavioural reference model
  int m_mode, m_flags, m_s1, m_s2, m_s3;
  int m_pre[2], m_match[2], m_cnt[2], m_pc[2], m_cap[4];

  always @(posedge clk) begin : model
    int pls, ev, cp, setm, clr, v, mv;
    bit mw, t0, t1, wide, i0, i1;
    if (!rst_n) begin
      m_mode = 0; m_flags = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
      for (int i = 0; i < 2; i++) begin
        m_pre[i] = 0; m_match[i] = 255; m_cnt[i] = 0; m_pc[i] = 0;
      end
      for (int i = 0; i < 4; i++) m_cap[i] = 0;
    end else begin
      pls = m_s2 & ~m_s3;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = {cap_in, evt_in};
      ev = pls & 1; cp = (pls >> 1) & 15;
      mw = wr_en && addr == 0;
      t0 = m_pc[0] >= m_pre[0];
      t1 = m_pc[1] >= m_pre[1];
      m_pc[0] = mw ? 0 : (t0 ? 0 : m_pc[0] + 1);
      m_pc[1] = mw ? 0 : (t1 ? 0 : m_pc[1] + 1);
      wide = m_mode >= 2;
      setm = 0;
      for (int j = 0; j < 2; j++) begin
        if (wide) begin
          if (cp[j]) begin m_cap[2*j] = m_cnt[0]; m_cap[2*j+1] = m_cnt[1]; setm |= 4 << j; end
        end else begin
          if (cp[j])   begin m_cap[2*j] = m_cnt[0];   setm |= 4 << j; end
          if (cp[2+j]) begin m_cap[2*j+1] = m_cnt[1]; setm |= 16 << j; end
        end
      end
      if (mw) begin
        m_cnt[0] = 0; m_cnt[1] = 0;
      end else if (wide) begin
        if (m_mode == 2 ? t0 : ev[0]) begin
          v = m_cnt[1] * 256 + m_cnt[0];
          mv = m_match[1] * 256 + m_match[0];
          if (v == mv) begin v = 0; setm |= 1; end else v = (v + 1) % 65536;
          m_cnt[0] = v % 256; m_cnt[1] = v / 256;
        end
      end else begin
        i0 = t0;
        i1 = (m_mode == 0) ? t1 : ev[0];
        if (i0) begin
          if (m_cnt[0] == m_match[0]) begin m_cnt[0] = 0; setm |= 1; end else m_cnt[0] = (m_cnt[0] + 1) % 256;
        end
        if (i1) begin
          if (m_cnt[1] == m_match[1]) begin m_cnt[1] = 0; setm |= 2; end else m_cnt[1] = (m_cnt[1] + 1) % 256;
        end
      end
      clr = (wr_en && addr == 5) ? (wr_data & 63) : 0;
      m_flags = ((m_flags & ~clr) | setm) & 63;
      if (wr_en) begin
        case (addr)
          0: m_mode = wr_data & 3;
          1: m_pre[0] = wr_data;
          2: m_pre[1] = wr_data;
          3: m_match[0] = wr_data;
          4: m_match[1] = wr_data;
          default: ;
        endcase
      end
    end
  end

  function automatic int model_rd(input int a);
    case (a)
      0: return m_mode;
      1: return m_pre[0];
      2: return m_pre[1];
      3: return m_match[0];
      4: return m_match[1];
      5: return m_flags;
      6: return m_cnt[0];
      7: return m_cnt[1];
      8, 9, 10, 11: return m_cap[a-8];
      default: return 0;
    endcase
  endfunction

  function automatic string addr_tag(input int a);
    if (a <= 4) return "R13";
    if (a == 5) return "R5";
    if (a <= 7) return "R3";
    return "R10";
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(addr_tag(int'(addr)), "model compare rd_data", int'(rd_data), model_rd(int'(addr)));
      chk("R4", "model compare irq_lo", int'(irq_lo), m_flags & 1);
      chk("R4", "model compare irq_hi", int'(irq_hi), (m_flags >> 1) & 1);
    end
  end

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
      if (!wr_en) addr = (addr == 4'd11) ? 4'd0 : addr + 4'd1;
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; addr = a[3:0]; wr_data = d[7:0];
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    addr = a[3:0];
    #0.5;
    v = int'(rd_data);
  endtask

  task automatic pulse(input int b);
    if (b == 0) evt_in = 1'b1; else cap_in[b-1] = 1'b1;
    tick(2);
    if (b == 0) evt_in = 1'b0; else cap_in[b-1] = 1'b0;
    tick(2);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : stim
    int v, keep;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(0, v); chk("R1", "mode after reset", v, 0);
    rd(1, v); chk("R1", "low prescale after reset", v, 0);
    rd(3, v); chk("R1", "low match after reset", v, 8'hFF);
    rd(4, v); chk("R1", "high match after reset", v, 8'hFF);
    rd(5, v); chk("R1", "flags after reset", v, 0);
    rd(11, v); chk("R1", "capture after reset", v, 0);
    chk("R1", "irq_lo after reset", int'(irq_lo), 0);

    // R13: readback
    wr(1, 3);
    rd(1, v); chk("R13", "low prescale readback", v, 3);

    // R2: capture latency through synchronizer
    wr(5, 8'h3F);
    cap_in[0] = 1'b1;
    tick(1);
    tick(1); rd(5, v); chk("R2", "capture flag one edge early", v & 4, 0);
    tick(1); rd(5, v); chk("R2", "capture flag at k+2", v & 4, 4);
    cap_in[0] = 1'b0;
    tick(2);

    // R3 / R6 / R4 / R5 in mode 0
    wr(2, 0); wr(3, 8'hFF); wr(4, 9); wr(5, 8'h3F); wr(0, 0);
    tick(8);
    rd(6, v); chk("R3", "low count after 8 cycles, prescale 3", v, 2);
    rd(7, v); chk("R6", "high count after 8 cycles, prescale 0", v, 8);
    chk("R4", "irq_hi before match", int'(irq_hi), 0);
    tick(2);
    rd(7, v); chk("R4", "high count wraps on match", v, 0);
    chk("R4", "irq_hi after match", int'(irq_hi), 1);
    tick(2);
    chk("R5", "irq_hi sticky", int'(irq_hi), 1);
    wr(5, 8'h02);
    chk("R5", "irq_hi cleared by write-1", int'(irq_hi), 0);

    // R12: rewrite of the same mode clears counts
    wr(0, 0);
    rd(6, v); chk("R12", "low count after mode write", v, 0);
    rd(7, v); chk("R12", "high count after mode write", v, 0);

    // R7 / R10 in mode 1
    wr(0, 1);
    for (int i = 0; i < 5; i++) pulse(0);
    tick(2);
    rd(7, v); chk("R7", "high half event count", v, 5);
    wr(5, 8'h3F);
    pulse(3);
    tick(2);
    rd(9, v); chk("R10", "high primary capture", v, 5);
    rd(5, v); chk("R10", "high primary capture flag", v & 16, 16);

    // R8: 16-bit prescaled timer
    wr(0, 3);
    wr(1, 1); wr(3, 5); wr(4, 1); wr(5, 8'h3F);
    wr(0, 2);
    tick(522);
    rd(7, v); chk("R8", "16-bit count high byte at match", v, 1);
    rd(6, v); chk("R8", "16-bit count low byte at match", v, 5);
    chk("R8", "irq_lo before wrap", int'(irq_lo), 0);
    tick(2);
    rd(6, v); chk("R8", "16-bit count low after wrap", v, 0);
    rd(7, v); chk("R8", "16-bit count high after wrap", v, 0);
    chk("R8", "irq_lo after wrap", int'(irq_lo), 1);
    chk("R8", "irq_hi quiet in wide mode", int'(irq_hi), 0);

    // R9 / R11: 16-bit event counter
    wr(3, 8'hFF); wr(4, 8'hFF); wr(5, 8'h3F);
    wr(0, 3);
    for (int i = 0; i < 300; i++) pulse(0);
    tick(2);
    rd(6, v); chk("R9", "16-bit event count low", v, 8'h2C);
    rd(7, v); chk("R9", "16-bit event count high", v, 8'h01);
    pulse(1);
    tick(2);
    rd(8, v); chk("R11", "wide primary capture low", v, 8'h2C);
    rd(9, v); chk("R11", "wide primary capture high", v, 8'h01);
    rd(5, v); chk("R11", "wide primary capture flag", v & 4, 4);
    rd(11, keep);
    pulse(4);
    tick(2);
    rd(11, v); chk("R11", "high secondary strobe ignored in wide mode", v, keep);
    rd(5, v); chk("R11", "no flag for ignored strobe", v & 32, 0);

    // R13: read-only count address ignores writes
    wr(6, 8'hAA);
    rd(6, v); chk("R13", "count not writable", v, 8'h2C);
    tick(4);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule